// File: doc/BRIEF.md
# Translation Fault Syndrome Recorder

This block sits beside a two-level (guest and hypervisor) address translation unit. It turns a single-cycle fault report into the architectural syndrome state that a trap handler reads. Each report carries a fault kind, an access type, the effective address, the guest real address and a cause bitmask. The block routes the cause into the correct syndrome register for the fault level and access type. It captures the relevant addresses and emits a one-cycle exception code.

The block also resolves the address-space context of an effective address. The top two address bits form a quadrant. The quadrant, together with the hypervisor-mode flag, selects which partition identifier and which process identifier apply. An illegal quadrant outside hypervisor mode becomes a segment fault without any outside help. The current partition, current process and hypervisor-mode inputs are sampled in the same cycle as the request.

Top module: `xlate_fault_recorder`

## Requirements
- R1: After reset, every syndrome register, the error code and the context outputs are zero, and no exception, error or context pulse is present.
- R2: A segment fault (kind 0) on a fetch (access 0) gives exception code 1, clears the error code and leaves all address registers unchanged.
- R3: A segment fault on a load (access 1) or store (access 2) gives exception code 2, captures the effective address in the data address register and clears the error code.
- R4: A guest storage fault (kind 1) on a fetch gives exception code 3 and loads the cause into the error code.
- R5: A guest storage fault on a load or store gives exception code 4, writes the cause to the data syndrome register and the effective address to the data address register, and clears the error code.
- R6: For a store, bit STORE_BIT is ORed into the cause before it is written, on both the guest path and the host path.
- R7: A host storage fault (kind 2) on a fetch gives exception code 5, writes the guest real address to the guest-address syndrome register and loads the cause into the error code.
- R8: A host storage fault on a load or store gives exception code 6, writes the host data syndrome register, the host data address register (effective address) and the guest-address syndrome register (guest real address), and clears the error code.
- R9: A context request (kind 3) in hypervisor mode maps quadrant 0 to (partition 0, current process), quadrant 1 to (current partition, current process), quadrant 2 to (current partition, process 0) and quadrant 3 to (partition 0, process 0). It pulses the context valid output.
- R10: A context request outside hypervisor mode maps quadrant 0 to (current partition, current process) and quadrant 3 to (current partition, process 0). Quadrants 1 and 2 raise a segment fault exactly as in R2/R3 and give no context pulse.
- R11: Every update and pulse appears on the clock edge after the request and lasts one cycle. Nothing changes in a cycle without a request.
- R12: A request with access code 3 pulses the error output, raises no exception or context pulse, and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fault or context request strobe |
| req_kind | input | 2 | 0 segment, 1 guest storage, 2 host storage, 3 context |
| req_access | input | 2 | 0 fetch, 1 load, 2 store, 3 illegal |
| req_ea | input | EA_W | Effective address |
| req_gra | input | RA_W | Guest real address |
| req_cause | input | CAUSE_W | Cause bitmask |
| hv_mode | input | 1 | Hypervisor-mode flag |
| cur_lpid | input | LPID_W | Current partition identifier |
| cur_pid | input | PID_W | Current process identifier |
| exc_valid | output | 1 | Exception pulse |
| exc_code | output | 3 | Exception code (1..6) |
| bad_req | output | 1 | Illegal-access pulse |
| ctx_valid | output | 1 | Context resolved pulse |
| ctx_lpid | output | LPID_W | Resolved partition identifier |
| ctx_pid | output | PID_W | Resolved process identifier |
| daddr | output | EA_W | Data address register |
| dsynd | output | CAUSE_W | Data syndrome register |
| hdaddr | output | EA_W | Host data address register |
| hdsynd | output | CAUSE_W | Host data syndrome register |
| gra_synd | output | RA_W | Guest-address syndrome register |
| err_code | output | CAUSE_W | Error code |

## Verification
The bench uses EA_W=16 and RA_W=24. With these widths, random addresses cover all four quadrants evenly and values are easy to read. LPID_W=4 and PID_W=6 make a current identifier of zero appear often. This helps separate the quadrants that force an identifier to zero from those that pass a zero through. CAUSE_W stays at 32 with STORE_BIT=25, so random causes both already hold and lack the store bit.

// File: rtl/xfr_pkg.sv
package xfr_pkg;
  typedef enum logic [1:0] {
    K_SEG   = 2'd0,
    K_GUEST = 2'd1,
    K_HOST  = 2'd2,
    K_CTX   = 2'd3
  } fault_kind_e;

  typedef enum logic [1:0] {
    A_FETCH = 2'd0,
    A_LOAD  = 2'd1,
    A_STORE = 2'd2,
    A_BAD   = 2'd3
  } access_e;

  typedef enum logic [2:0] {
    X_NONE  = 3'd0,
    X_ISEG  = 3'd1,
    X_DSEG  = 3'd2,
    X_ISTOR = 3'd3,
    X_DSTOR = 3'd4,
    X_HISTO = 3'd5,
    X_HDSTO = 3'd6
  } exc_e;
endpackage

// File: rtl/xfr_rst_sync.sv
module xfr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/xfr_ctx_decode.sv
module xfr_ctx_decode #(
  parameter int LPID_W = 12,
  parameter int PID_W  = 20
) (
  input  logic [1:0]        quadrant,
  input  logic              hv_mode,
  input  logic [LPID_W-1:0] cur_lpid,
  input  logic [PID_W-1:0]  cur_pid,
  output logic              legal,
  output logic [LPID_W-1:0] lpid,
  output logic [PID_W-1:0]  pid
);
  always_comb begin
    legal = 1'b1;
    lpid  = '0;
    pid   = '0;
    if (hv_mode) begin
      unique case (quadrant)
        2'd0: begin lpid = '0;       pid = cur_pid; end
        2'd1: begin lpid = cur_lpid; pid = cur_pid; end
        2'd2: begin lpid = cur_lpid; pid = '0;      end
        default: begin lpid = '0;    pid = '0;      end
      endcase
    end else begin
      unique case (quadrant)
        2'd0: begin lpid = cur_lpid; pid = cur_pid; end
        2'd3: begin lpid = cur_lpid; pid = '0;      end
        default: legal = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/xfr_router.sv
module xfr_router
  import xfr_pkg::*;
#(
  parameter int EA_W      = 64,
  parameter int RA_W      = 64,
  parameter int CAUSE_W   = 32,
  parameter int STORE_BIT = 25,
  parameter int LPID_W    = 12,
  parameter int PID_W     = 20
) (
  input  logic               req_valid,
  input  logic [1:0]         req_kind,
  input  logic [1:0]         req_access,
  input  logic [EA_W-1:0]    req_ea,
  input  logic [RA_W-1:0]    req_gra,
  input  logic [CAUSE_W-1:0] req_cause,
  input  logic               ctx_legal,
  output logic               we_daddr,
  output logic               we_dsynd,
  output logic               we_hdaddr,
  output logic               we_hdsynd,
  output logic               we_gra,
  output logic               we_err,
  output logic [CAUSE_W-1:0] synd_val,
  output logic [CAUSE_W-1:0] err_val,
  output logic [EA_W-1:0]    addr_val,
  output logic [RA_W-1:0]    gra_val,
  output logic               fire_exc,
  output logic [2:0]         code_val,
  output logic               fire_bad,
  output logic               fire_ctx
);
  localparam logic [CAUSE_W-1:0] STORE_MASK = CAUSE_W'(1) << STORE_BIT;

  fault_kind_e kind;
  access_e     acc;
  logic        is_fetch;
  logic        seg_path;

  assign kind     = fault_kind_e'(req_kind);
  assign acc      = access_e'(req_access);
  assign is_fetch = (acc == A_FETCH);
  assign synd_val = req_cause | ((acc == A_STORE) ? STORE_MASK : '0);
  assign addr_val = req_ea;
  assign gra_val  = req_gra;
  assign seg_path = (kind == K_SEG) || ((kind == K_CTX) && !ctx_legal);

  always_comb begin
    we_daddr  = 1'b0;
    we_dsynd  = 1'b0;
    we_hdaddr = 1'b0;
    we_hdsynd = 1'b0;
    we_gra    = 1'b0;
    we_err    = 1'b0;
    err_val   = '0;
    fire_exc  = 1'b0;
    code_val  = X_NONE;
    fire_bad  = 1'b0;
    fire_ctx  = 1'b0;
    if (req_valid) begin
      if (acc == A_BAD) begin
        fire_bad = 1'b1;
      end else if (seg_path) begin
        fire_exc = 1'b1;
        we_err   = 1'b1;
        code_val = is_fetch ? X_ISEG : X_DSEG;
        we_daddr = !is_fetch;
      end else if (kind == K_CTX) begin
        fire_ctx = 1'b1;
      end else if (kind == K_GUEST) begin
        fire_exc = 1'b1;
        we_err   = 1'b1;
        if (is_fetch) begin
          code_val = X_ISTOR;
          err_val  = req_cause;
        end else begin
          code_val = X_DSTOR;
          we_dsynd = 1'b1;
          we_daddr = 1'b1;
        end
      end else begin
        fire_exc = 1'b1;
        we_err   = 1'b1;
        we_gra   = 1'b1;
        if (is_fetch) begin
          code_val = X_HISTO;
          err_val  = req_cause;
        end else begin
          code_val  = X_HDSTO;
          we_hdsynd = 1'b1;
          we_hdaddr = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xfr_regs.sv
module xfr_regs #(
  parameter int EA_W    = 64,
  parameter int RA_W    = 64,
  parameter int CAUSE_W = 32,
  parameter int LPID_W  = 12,
  parameter int PID_W   = 20
) (
  input  logic               clk,
  input  logic               rst_sync_n,
  input  logic               we_daddr,
  input  logic               we_dsynd,
  input  logic               we_hdaddr,
  input  logic               we_hdsynd,
  input  logic               we_gra,
  input  logic               we_err,
  input  logic [CAUSE_W-1:0] synd_val,
  input  logic [CAUSE_W-1:0] err_val,
  input  logic [EA_W-1:0]    addr_val,
  input  logic [RA_W-1:0]    gra_val,
  input  logic               fire_exc,
  input  logic [2:0]         code_val,
  input  logic               fire_bad,
  input  logic               fire_ctx,
  input  logic [LPID_W-1:0]  ctx_lpid_val,
  input  logic [PID_W-1:0]   ctx_pid_val,
  output logic [EA_W-1:0]    daddr_q,
  output logic [CAUSE_W-1:0] dsynd_q,
  output logic [EA_W-1:0]    hdaddr_q,
  output logic [CAUSE_W-1:0] hdsynd_q,
  output logic [RA_W-1:0]    gra_q,
  output logic [CAUSE_W-1:0] err_q,
  output logic               exc_q,
  output logic [2:0]         code_q,
  output logic               bad_q,
  output logic               ctxv_q,
  output logic [LPID_W-1:0]  ctx_lpid_q,
  output logic [PID_W-1:0]   ctx_pid_q
);
  logic [EA_W-1:0]    daddr_d, hdaddr_d;
  logic [CAUSE_W-1:0] dsynd_d, hdsynd_d, err_d;
  logic [RA_W-1:0]    gra_d;
  logic [2:0]         code_d;
  logic [LPID_W-1:0]  ctx_lpid_d;
  logic [PID_W-1:0]   ctx_pid_d;

  always_comb begin
    daddr_d    = we_daddr  ? addr_val     : daddr_q;
    dsynd_d    = we_dsynd  ? synd_val     : dsynd_q;
    hdaddr_d   = we_hdaddr ? addr_val     : hdaddr_q;
    hdsynd_d   = we_hdsynd ? synd_val     : hdsynd_q;
    gra_d      = we_gra    ? gra_val      : gra_q;
    err_d      = we_err    ? err_val      : err_q;
    code_d     = fire_exc  ? code_val     : code_q;
    ctx_lpid_d = fire_ctx  ? ctx_lpid_val : ctx_lpid_q;
    ctx_pid_d  = fire_ctx  ? ctx_pid_val  : ctx_pid_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      daddr_q    <= '0;
      dsynd_q    <= '0;
      hdaddr_q   <= '0;
      hdsynd_q   <= '0;
      gra_q      <= '0;
      err_q      <= '0;
      exc_q      <= 1'b0;
      code_q     <= '0;
      bad_q      <= 1'b0;
      ctxv_q     <= 1'b0;
      ctx_lpid_q <= '0;
      ctx_pid_q  <= '0;
    end else begin
      daddr_q    <= daddr_d;
      dsynd_q    <= dsynd_d;
      hdaddr_q   <= hdaddr_d;
      hdsynd_q   <= hdsynd_d;
      gra_q      <= gra_d;
      err_q      <= err_d;
      exc_q      <= fire_exc;
      code_q     <= code_d;
      bad_q      <= fire_bad;
      ctxv_q     <= fire_ctx;
      ctx_lpid_q <= ctx_lpid_d;
      ctx_pid_q  <= ctx_pid_d;
    end
  end
endmodule

// File: rtl/xlate_fault_recorder.sv
module xlate_fault_recorder
  import xfr_pkg::*;
#(
  parameter int EA_W      = 64,
  parameter int RA_W      = 64,
  parameter int CAUSE_W   = 32,
  parameter int STORE_BIT = 25,
  parameter int LPID_W    = 12,
  parameter int PID_W     = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_kind,
  input  logic [1:0]         req_access,
  input  logic [EA_W-1:0]    req_ea,
  input  logic [RA_W-1:0]    req_gra,
  input  logic [CAUSE_W-1:0] req_cause,
  input  logic               hv_mode,
  input  logic [LPID_W-1:0]  cur_lpid,
  input  logic [PID_W-1:0]   cur_pid,
  output logic               exc_valid,
  output logic [2:0]         exc_code,
  output logic               bad_req,
  output logic               ctx_valid,
  output logic [LPID_W-1:0]  ctx_lpid,
  output logic [PID_W-1:0]   ctx_pid,
  output logic [EA_W-1:0]    daddr,
  output logic [CAUSE_W-1:0] dsynd,
  output logic [EA_W-1:0]    hdaddr,
  output logic [CAUSE_W-1:0] hdsynd,
  output logic [RA_W-1:0]    gra_synd,
  output logic [CAUSE_W-1:0] err_code
);
  localparam int QHI = EA_W - 1;
  localparam int QLO = EA_W - 2;

  logic               rst_sync_n;
  logic               ctx_legal;
  logic [LPID_W-1:0]  dec_lpid;
  logic [PID_W-1:0]   dec_pid;
  logic               we_daddr, we_dsynd, we_hdaddr, we_hdsynd, we_gra, we_err;
  logic [CAUSE_W-1:0] synd_val, err_val;
  logic [EA_W-1:0]    addr_val;
  logic [RA_W-1:0]    gra_val;
  logic               fire_exc, fire_bad, fire_ctx;
  logic [2:0]         code_val;

  xfr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  xfr_ctx_decode #(.LPID_W(LPID_W), .PID_W(PID_W)) u_ctx (
    .quadrant (req_ea[QHI:QLO]),
    .hv_mode  (hv_mode),
    .cur_lpid (cur_lpid),
    .cur_pid  (cur_pid),
    .legal    (ctx_legal),
    .lpid     (dec_lpid),
    .pid      (dec_pid)
  );

  xfr_router #(
    .EA_W(EA_W), .RA_W(RA_W), .CAUSE_W(CAUSE_W), .STORE_BIT(STORE_BIT),
    .LPID_W(LPID_W), .PID_W(PID_W)
  ) u_route (
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .req_access (req_access),
    .req_ea     (req_ea),
    .req_gra    (req_gra),
    .req_cause  (req_cause),
    .ctx_legal  (ctx_legal),
    .we_daddr   (we_daddr),
    .we_dsynd   (we_dsynd),
    .we_hdaddr  (we_hdaddr),
    .we_hdsynd  (we_hdsynd),
    .we_gra     (we_gra),
    .we_err     (we_err),
    .synd_val   (synd_val),
    .err_val    (err_val),
    .addr_val   (addr_val),
    .gra_val    (gra_val),
    .fire_exc   (fire_exc),
    .code_val   (code_val),
    .fire_bad   (fire_bad),
    .fire_ctx   (fire_ctx)
  );

  xfr_regs #(
    .EA_W(EA_W), .RA_W(RA_W), .CAUSE_W(CAUSE_W), .LPID_W(LPID_W), .PID_W(PID_W)
  ) u_regs (
    .clk          (clk),
    .rst_sync_n   (rst_sync_n),
    .we_daddr     (we_daddr),
    .we_dsynd     (we_dsynd),
    .we_hdaddr    (we_hdaddr),
    .we_hdsynd    (we_hdsynd),
    .we_gra       (we_gra),
    .we_err       (we_err),
    .synd_val     (synd_val),
    .err_val      (err_val),
    .addr_val     (addr_val),
    .gra_val      (gra_val),
    .fire_exc     (fire_exc),
    .code_val     (code_val),
    .fire_bad     (fire_bad),
    .fire_ctx     (fire_ctx),
    .ctx_lpid_val (dec_lpid),
    .ctx_pid_val  (dec_pid),
    .daddr_q      (daddr),
    .dsynd_q      (dsynd),
    .hdaddr_q     (hdaddr),
    .hdsynd_q     (hdsynd),
    .gra_q        (gra_synd),
    .err_q        (err_code),
    .exc_q        (exc_valid),
    .code_q       (exc_code),
    .bad_q        (bad_req),
    .ctxv_q       (ctx_valid),
    .ctx_lpid_q   (ctx_lpid),
    .ctx_pid_q    (ctx_pid)
  );

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !exc_valid && !bad_req && !ctx_valid && $stable(daddr) &&
                   $stable(dsynd) && $stable(hdaddr) && $stable(hdsynd) &&
                   $stable(gra_synd) && $stable(err_code));

  // R12
  bad_access_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_access == 2'd3) |=> bad_req && !exc_valid && !ctx_valid &&
                   $stable(daddr) && $stable(dsynd) && $stable(err_code));

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({exc_valid, bad_req, ctx_valid}));

  // R6
  guest_store_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_kind == 2'd1 && req_access == 2'd2) |=> dsynd[STORE_BIT]);

  // R6
  host_store_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_kind == 2'd2 && req_access == 2'd2) |=> hdsynd[STORE_BIT]);

  // R8
  host_gra_capture_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_kind == 2'd2 && req_access != 2'd3) |=> gra_synd == $past(req_gra));

  // R10
  illegal_quadrant_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_kind == 2'd3 && !hv_mode && req_access != 2'd3 &&
     (req_ea[QHI:QLO] == 2'd1 || req_ea[QHI:QLO] == 2'd2))
    |=> exc_valid && !ctx_valid && (exc_code == 3'd1 || exc_code == 3'd2));
endmodule

// File: tb/xlate_fault_recorder_bench.sv
module xlate_fault_recorder_bench;
  localparam int EA_W = 16, RA_W = 24, CAUSE_W = 32, SB = 25, LW = 4, PW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = '0, req_access = '0;
  logic [EA_W-1:0] req_ea = '0;
  logic [RA_W-1:0] req_gra = '0;
  logic [CAUSE_W-1:0] req_cause = '0;
  logic hv_mode = 1'b0;
  logic [LW-1:0] cur_lpid = '0;
  logic [PW-1:0] cur_pid = '0;
  logic exc_valid, bad_req, ctx_valid;
  logic [2:0] exc_code;
  logic [LW-1:0] ctx_lpid;
  logic [PW-1:0] ctx_pid;
  logic [EA_W-1:0] daddr, hdaddr;
  logic [CAUSE_W-1:0] dsynd, hdsynd, err_code;
  logic [RA_W-1:0] gra_synd;

  xlate_fault_recorder #(.EA_W(EA_W), .RA_W(RA_W), .CAUSE_W(CAUSE_W),
    .STORE_BIT(SB), .LPID_W(LW), .PID_W(PW)) u_xlate_fault_recorder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_access(req_access), .req_ea(req_ea), .req_gra(req_gra),
    .req_cause(req_cause), .hv_mode(hv_mode), .cur_lpid(cur_lpid),
    .cur_pid(cur_pid), .exc_valid(exc_valid), .exc_code(exc_code),
    .bad_req(bad_req), .ctx_valid(ctx_valid), .ctx_lpid(ctx_lpid),
    .ctx_pid(ctx_pid), .daddr(daddr), .dsynd(dsynd), .hdaddr(hdaddr),
    .hdsynd(hdsynd), .gra_synd(gra_synd), .err_code(err_code));

  always #2.5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // expected model state
  logic [EA_W-1:0] e_daddr = '0, e_hdaddr = '0;
  logic [CAUSE_W-1:0] e_dsynd = '0, e_hdsynd = '0, e_err = '0;
  logic [RA_W-1:0] e_gra = '0;
  logic e_exc = 1'b0, e_bad = 1'b0, e_ctxv = 1'b0;
  logic [2:0] e_code = '0;
  logic [LW-1:0] e_lp = '0;
  logic [PW-1:0] e_pd = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] k, input logic [1:0] a, input logic h);
    if (a == 2'd3) return "R12";
    if (k == 2'd3) return h ? "R9" : "R10";
    if (k == 2'd0) return (a == 2'd0) ? "R2" : "R3";
    if (k == 2'd1) return (a == 2'd0) ? "R4" : ((a == 2'd2) ? "R6" : "R5");
    return (a == 2'd0) ? "R7" : ((a == 2'd2) ? "R6" : "R8");
  endfunction

  task automatic model(input logic v, input logic [1:0] k, input logic [1:0] a,
                       input logic [EA_W-1:0] ea, input logic [RA_W-1:0] gr,
                       input logic [CAUSE_W-1:0] c, input logic h,
                       input logic [LW-1:0] lp, input logic [PW-1:0] pd);
    logic [1:0] q;
    logic [CAUSE_W-1:0] cs;
    logic seg;
    q = ea[EA_W-1:EA_W-2];
    cs = c | ((a == 2'd2) ? (32'd1 << SB) : 32'd0);
    e_exc = 1'b0; e_bad = 1'b0; e_ctxv = 1'b0;
    if (!v) return;
    if (a == 2'd3) begin e_bad = 1'b1; return; end
    seg = (k == 2'd0);
    if (k == 2'd3) begin
      if (h) begin
        e_ctxv = 1'b1;
        e_lp = (q == 2'd1 || q == 2'd2) ? lp : '0;
        e_pd = (q == 2'd0 || q == 2'd1) ? pd : '0;
      end else if (q == 2'd0 || q == 2'd3) begin
        e_ctxv = 1'b1;
        e_lp = lp;
        e_pd = (q == 2'd0) ? pd : '0;
      end else seg = 1'b1;
      if (!seg) return;
    end
    e_exc = 1'b1;
    if (seg) begin
      e_err = '0;
      if (a == 2'd0) e_code = 3'd1;
      else begin e_code = 3'd2; e_daddr = ea; end
    end else if (k == 2'd1) begin
      if (a == 2'd0) begin e_code = 3'd3; e_err = c; end
      else begin e_code = 3'd4; e_dsynd = cs; e_daddr = ea; e_err = '0; end
    end else begin
      e_gra = gr;
      if (a == 2'd0) begin e_code = 3'd5; e_err = c; end
      else begin e_code = 3'd6; e_hdsynd = cs; e_hdaddr = ea; e_err = '0; end
    end
  endtask

  task automatic check_all(input string t);
    chk({t, " exc_valid"}, 64'(exc_valid), 64'(e_exc));
    if (e_exc) chk({t, " exc_code"}, 64'(exc_code), 64'(e_code));
    chk({t, " bad_req"}, 64'(bad_req), 64'(e_bad));
    chk({t, " ctx_valid"}, 64'(ctx_valid), 64'(e_ctxv));
    chk({t, " ctx_lpid"}, 64'(ctx_lpid), 64'(e_lp));
    chk({t, " ctx_pid"}, 64'(ctx_pid), 64'(e_pd));
    chk({t, " daddr"}, 64'(daddr), 64'(e_daddr));
    chk({t, " dsynd"}, 64'(dsynd), 64'(e_dsynd));
    chk({t, " hdaddr"}, 64'(hdaddr), 64'(e_hdaddr));
    chk({t, " hdsynd"}, 64'(hdsynd), 64'(e_hdsynd));
    chk({t, " gra_synd"}, 64'(gra_synd), 64'(e_gra));
    chk({t, " err_code"}, 64'(err_code), 64'(e_err));
  endtask

  // drive at a negedge, check at the following negedge (one register stage)
  task automatic step(input logic v, input logic [1:0] k, input logic [1:0] a,
                      input logic [EA_W-1:0] ea, input logic [RA_W-1:0] gr,
                      input logic [CAUSE_W-1:0] c, input logic h,
                      input logic [LW-1:0] lp, input logic [PW-1:0] pd);
    req_valid = v; req_kind = k; req_access = a; req_ea = ea; req_gra = gr;
    req_cause = c; hv_mode = h; cur_lpid = lp; cur_pid = pd;
    model(v, k, a, ea, gr, c, h, lp, pd);
    @(negedge clk);
    check_all(v ? tag_of(k, a, h) : "R11 idle");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    // directed: every kind x access
    for (int k = 0; k < 3; k++)
      for (int a = 0; a < 4; a++)
        step(1'b1, 2'(k), 2'(a), 16'h1234 + 16'(k*4+a), 24'hA00000 + 24'(k*16+a),
             32'h0000_00F0 + 32'(a), 1'b0, 4'd3, 6'd9);
    // store flag when already set
    step(1'b1, 2'd1, 2'd2, 16'h0F00, 24'h1, 32'h0200_0001, 1'b0, 4'd1, 6'd1);
    step(1'b0, 2'd0, 2'd0, 16'hFFFF, 24'hFFFFFF, 32'hFFFF_FFFF, 1'b0, 4'd1, 6'd1);
    // all quadrants, both modes, zero and non-zero identifiers
    for (int h = 0; h < 2; h++)
      for (int q = 0; q < 4; q++) begin
        step(1'b1, 2'd3, 2'd1, {2'(q), 14'h0155}, 24'h0, 32'h7, 1'(h), 4'd5, 6'd33);
        step(1'b1, 2'd3, 2'd0, {2'(q), 14'h2AAA}, 24'h0, 32'h7, 1'(h), 4'd0, 6'd0);
      end
    step(1'b1, 2'd3, 2'd3, 16'h4000, 24'h0, 32'h0, 1'b0, 4'd2, 6'd2);
    // random mix
    for (int i = 0; i < 2000; i++) begin
      step(($urandom % 5) != 0, 2'($urandom), 2'($urandom), 16'($urandom),
           24'($urandom), $urandom, 1'($urandom), 4'($urandom % 3 == 0 ? 0 : $urandom),
           6'($urandom % 3 == 0 ? 0 : $urandom));
    end
    step(1'b0, 2'd0, 2'd0, 16'h0, 24'h0, 32'h0, 1'b0, 4'd0, 6'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule